// File: doc/BRIEF.md
# Bitmap Page Range Allocator

This block hands out and takes back runs of translation-table page slots. Its only store is an occupancy bitmap with one bit per slot, where a set bit means the slot is taken. Bit 0 stands for the lowest I/O virtual page. An allocate request carries a page count. The block rounds that count up to an aligned group of 8, 16, 32 or 64 slots, searches the bitmap for a group that is entirely clear, marks the whole group as taken and returns the index of its first slot. A release request carries a slot index and a page count and clears the aligned group that those pages occupy.

The search starts at a stored position called the hint and tests one aligned group per clock cycle. It wraps around the top of the map, and after a full lap with no success it gives up. When a grant succeeds, the hint moves to the slot just past the granted group. Because the search starts there, short-lived mappings tend to land on fresh slots in turn instead of always reusing the lowest ones.

A reserve mask input marks slots that may never be granted. Requests enter through a valid/ready channel, and only one request is in flight at a time. Every request gets a one-cycle response that carries a slot index and an error code.

Top module: `page_range_alloc`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, the bitmap is all clear and the hint is slot 16. The first allocation of 1 to 8 pages therefore returns index 16.
- R2: An allocation of 0 to 8 pages claims an entire 8-slot group aligned to a multiple of 8. The next small allocation gets the following group, even when fewer than 8 pages were asked for.
- R3: An allocation of 9 to 16 pages claims an aligned 16-slot group. One of 17 to 32 pages claims an aligned 32-slot group. One of 33 to 64 pages claims an aligned 64-slot group.
- R4: An allocation of more than 64 pages is answered with rsp_err = 1 and rsp_index = 0. It changes neither the bitmap nor the hint.
- R5: The search begins at the hint rounded down to the request's group size and advances one group at a time, wrapping from the top of the map to slot 0. On success the hint becomes the granted index plus the group size, modulo the map size.
- R6: A group is granted only if none of its slots is taken. A group with even one taken slot is skipped.
- R7: If no group is free after every group of that size has been tested once, the response carries rsp_err = 2 and rsp_index = 0. The bitmap and the hint are left unchanged.
- R8: A slot whose rsv_mask bit is 1 is never part of a granted group, whatever the state of its bitmap bit.
- R9: A release (req_op = 1) clears the aligned group that holds req_index and is sized by req_count. It answers with rsp_err = 0 and rsp_index set to that group's first slot, and the cleared slots can be granted again.
- R10: req_ready is 0 from the cycle after a request is accepted until the cycle after its response. A release offered during a search waits and is taken afterwards.
- R11: rsp_valid is a single-cycle pulse for each accepted request, and rsp_err = 0 marks success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_count | input | CNT_W | Page count |
| req_index | input | IDX_W | First slot of a release |
| rsv_mask | input | NUM_SLOTS | Slots barred from allocation (1 = barred) |
| rsp_valid | output | 1 | Response pulse |
| rsp_index | output | IDX_W | Granted or released group start |
| rsp_err | output | 2 | 0 ok, 1 too many pages, 2 no free group |

## Verification
A hint that is wrong in any way shows up in the index of the very next grant, so the bench checks an exact index for every allocation. If the bitmap is corrupted, a later grant either lands on a group that is still occupied or skips a group that is free. Either mistake appears at rsp_index within one search, which is no more than a lap of the map. The bench chains requests so that each grant depends on every earlier claim, every release and the reserve mask. A bad lap count shows up as a failure reported while free groups remain, or as a response that arrives too late.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_RESP   = 2'd2
    } alloc_state_e;

    localparam logic       OP_ALLOC    = 1'b0;
    localparam logic       OP_RELEASE  = 1'b1;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_TOO_BIG = 2'd1;
    localparam logic [1:0] ERR_NO_ROOM = 2'd2;

    localparam int         MAX_PAGES   = 64;
    localparam int         MIN_GROUP   = 8;

endpackage

// File: rtl/page_size_class.sv
// Maps a page count to a group-size class: 0 -> 8, 1 -> 16, 2 -> 32, 3 -> 64 slots.
module page_size_class #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    output logic [1:0]       size_cls,
    output logic             too_big
);
    always_comb begin
        too_big  = int'(count) > page_alloc_pkg::MAX_PAGES;
        if (int'(count) <= 8)       size_cls = 2'd0;
        else if (int'(count) <= 16) size_cls = 2'd1;
        else if (int'(count) <= 32) size_cls = 2'd2;
        else                        size_cls = 2'd3;
    end
endmodule

// File: rtl/page_group_probe.sv
// Tests one aligned group of the occupancy map and builds its slot mask.
module page_group_probe #(
    parameter int NUM_SLOTS = 256,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] used_map,
    input  logic [IDX_W-1:0]     base,
    input  logic [1:0]           size_cls,
    output logic                 grp_free,
    output logic [NUM_SLOTS-1:0] grp_mask
);
    logic [NUM_SLOTS-1:0] mask_v [4];
    logic [3:0]           free_v;

    for (genvar k = 0; k < 4; k++) begin : g_cls
        localparam int GW = page_alloc_pkg::MIN_GROUP << k;
        logic [NUM_SLOTS-1:0] unit_k;
        always_comb begin
            unit_k         = '0;
            unit_k[GW-1:0] = '1;
        end
        assign mask_v[k] = unit_k << base;
        assign free_v[k] = ~|(used_map & mask_v[k]);
    end

    assign grp_free = free_v[size_cls];
    assign grp_mask = mask_v[size_cls];
endmodule

// File: rtl/page_range_alloc.sv
module page_range_alloc #(
    parameter int NUM_SLOTS = 256,
    parameter int CNT_W     = 8,
    parameter int HINT_INIT = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int STEP_W   = IDX_W - 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_op,
    input  logic [CNT_W-1:0]     req_count,
    input  logic [IDX_W-1:0]     req_index,
    input  logic [NUM_SLOTS-1:0] rsv_mask,
    output logic                 rsp_valid,
    output logic [IDX_W-1:0]     rsp_index,
    output logic [1:0]           rsp_err
);
    import page_alloc_pkg::*;

    typedef struct packed {
        alloc_state_e         state;
        logic [NUM_SLOTS-1:0] map;
        logic [IDX_W-1:0]     hint;
        logic [IDX_W-1:0]     cur;
        logic [IDX_W-1:0]     idx;
        logic [STEP_W-1:0]    steps;
        logic [1:0]           cls;
        logic                 op;
        logic [1:0]           err;
    } regs_t;

    localparam regs_t RST_VAL = '{state: ST_IDLE, hint: IDX_W'(HINT_INIT), default: '0};

    regs_t q, d;

    // Lowest slot of the aligned group of class c that contains slot a.
    function automatic logic [IDX_W-1:0] align_dn(input logic [IDX_W-1:0] a, input logic [1:0] c);
        logic [IDX_W-1:0] lo;
        lo = IDX_W'((MIN_GROUP << c) - 1);
        return a & ~lo;
    endfunction

    // Group size in slots; wraps to zero when one group spans the whole map.
    function automatic logic [IDX_W-1:0] grp_size(input logic [1:0] c);
        return IDX_W'(MIN_GROUP << c);
    endfunction

    // Number of groups of class c in the map, minus one.
    function automatic logic [STEP_W-1:0] last_step(input logic [1:0] c);
        return STEP_W'((NUM_SLOTS >> (3 + c)) - 1);
    endfunction

    function automatic logic [NUM_SLOTS-1:0] unit_of(input logic [1:0] c);
        logic [NUM_SLOTS-1:0] u;
        for (int i = 0; i < NUM_SLOTS; i++) u[i] = (i < (MIN_GROUP << c));
        return u;
    endfunction

    logic [1:0]           req_cls;
    logic                 req_too_big;
    logic [1:0]           probe_cls;
    logic [IDX_W-1:0]     probe_base;
    logic                 probe_free;
    logic [NUM_SLOTS-1:0] probe_mask;
    logic [NUM_SLOTS-1:0] used_map;

    page_size_class #(.CNT_W(CNT_W)) i_size_class (
        .count    (req_count),
        .size_cls (req_cls),
        .too_big  (req_too_big)
    );

    assign used_map   = q.map | rsv_mask;
    assign probe_cls  = (q.state == ST_IDLE) ? req_cls : q.cls;
    assign probe_base = (q.state == ST_IDLE) ? align_dn(req_index, req_cls) : q.cur;

    page_group_probe #(.NUM_SLOTS(NUM_SLOTS)) i_group_probe (
        .used_map (used_map),
        .base     (probe_base),
        .size_cls (probe_cls),
        .grp_free (probe_free),
        .grp_mask (probe_mask)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op  = req_op;
                    d.cls = req_cls;
                    if (req_too_big) begin
                        d.err   = ERR_TOO_BIG;
                        d.idx   = '0;
                        d.state = ST_RESP;
                    end else if (req_op == OP_RELEASE) begin
                        d.map   = q.map & ~probe_mask;
                        d.idx   = probe_base;
                        d.err   = ERR_NONE;
                        d.state = ST_RESP;
                    end else begin
                        d.cur   = align_dn(q.hint, req_cls);
                        d.steps = '0;
                        d.state = ST_SEARCH;
                    end
                end
            end
            ST_SEARCH: begin
                if (probe_free) begin
                    d.map   = q.map | probe_mask;
                    d.idx   = q.cur;
                    d.err   = ERR_NONE;
                    d.hint  = q.cur + grp_size(q.cls);
                    d.state = ST_RESP;
                end else if (q.steps == last_step(q.cls)) begin
                    d.idx   = '0;
                    d.err   = ERR_NO_ROOM;
                    d.state = ST_RESP;
                end else begin
                    d.cur   = q.cur + grp_size(q.cls);
                    d.steps = q.steps + 1'b1;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign req_ready = (q.state == ST_IDLE);
    assign rsp_valid = (q.state == ST_RESP);
    assign rsp_index = q.idx;
    assign rsp_err   = q.err;

    // A grant starts on a boundary of its own group size (R2, R3).
    assert_grant_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.op == OP_ALLOC && rsp_err == ERR_NONE)
            |-> ((rsp_index & ~align_dn(rsp_index, q.cls)) == '0));

    // Every slot of a granted group is marked taken when the response is issued.
    assert_group_claimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.op == OP_ALLOC && rsp_err == ERR_NONE)
            |-> (((q.map >> rsp_index) & unit_of(q.cls)) == unit_of(q.cls)));

    // A failed search leaves the map as it was.
    assert_noroom_keeps_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == ERR_NO_ROOM) |-> $stable(q.map));

    // Barred slots never appear in a grant.
    assert_reserved_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.op == OP_ALLOC && rsp_err == ERR_NONE)
            |-> (((rsv_mask >> rsp_index) & unit_of(q.cls)) == '0));

    // Once a request is taken, nothing else is taken on the next cycle.
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // Each response lasts exactly one cycle.
    assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_page_range_alloc.sv
module test_page_range_alloc;
    localparam int NUM_SLOTS = 256;
    localparam int CNT_W     = 8;
    localparam int IDX_W     = $clog2(NUM_SLOTS);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_op = 1'b0;
    logic [CNT_W-1:0]     req_count = '0;
    logic [IDX_W-1:0]     req_index = '0;
    logic [NUM_SLOTS-1:0] rsv_mask = '0;
    logic                 rsp_valid;
    logic [IDX_W-1:0]     rsp_index;
    logic [1:0]           rsp_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    page_range_alloc #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .HINT_INIT(16)) i_page_range_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_count(req_count), .req_index(req_index),
        .rsv_mask(rsv_mask), .rsp_valid(rsp_valid), .rsp_index(rsp_index), .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issues one request, waits for its response and checks the response pulse ends (R11).
    task automatic do_req(input logic op, input int cnt, input int idx,
                          output int r_idx, output int r_err);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_op = op;
        req_count = CNT_W'(cnt); req_index = IDX_W'(idx);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 1000) begin @(negedge clk); n++; end
        r_idx = int'(rsp_index);
        r_err = rsp_valid ? int'(rsp_err) : -1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 single-cycle response", int'(rsp_valid), 0);
    endtask

    task automatic expect_alloc(input int cnt, input int exp_idx, input string req);
        int ri, re;
        do_req(1'b0, cnt, 0, ri, re);
        check(re == 0, {req, " error code"}, re, 0);
        check(ri == exp_idx, {req, " grant index"}, ri, exp_idx);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_small_groups();
        expect_alloc(3, 16, "R1 first grant at hint 16");
        expect_alloc(8, 24, "R2 small request takes whole group");
        expect_alloc(0, 32, "R2 zero pages uses 8-slot class");
    endtask

    task automatic t_larger_classes();
        expect_alloc(10, 48, "R3 16-slot group, R6 skips partly used group");
        expect_alloc(20, 64, "R3 32-slot group");
        expect_alloc(40, 128, "R3 64-slot group, R6 skip");
    endtask

    task automatic t_too_big();
        int ri, re;
        do_req(1'b0, 65, 0, ri, re);
        check(re == 1, "R4 oversize error code", re, 1);
        check(ri == 0, "R4 oversize index", ri, 0);
        expect_alloc(1, 192, "R4 hint unchanged after oversize");
    endtask

    // R7 lap exhaustion and R10 hold-off of a release offered mid-search.
    task automatic t_serialize_noroom();
        int held_ready;
        int ri, re;
        held_ready = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_count = CNT_W'(64); req_index = '0;
        @(posedge clk);
        @(negedge clk);
        req_op = 1'b1; req_count = CNT_W'(1); req_index = IDX_W'(200);
        while (!rsp_valid) begin
            if (req_ready) held_ready++;
            @(negedge clk);
        end
        if (req_ready) held_ready++;
        check(held_ready == 0, "R10 ready low during search", held_ready, 0);
        check(int'(rsp_err) == 2, "R7 no-room error code", int'(rsp_err), 2);
        check(int'(rsp_index) == 0, "R7 no-room index", int'(rsp_index), 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready back after response", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        ri = int'(rsp_index); re = int'(rsp_err);
        check(re == 0, "R10 held release completes", re, 0);
        check(ri == 200, "R9 release index aligned", ri, 200);
        @(negedge clk);
        expect_alloc(8, 200, "R7 hint and map unchanged after failure");
    endtask

    task automatic t_wrap();
        expect_alloc(32, 224, "R5 search moves upward");
        expect_alloc(8, 0, "R5 hint wraps to slot 0");
    endtask

    task automatic t_reserve();
        @(negedge clk);
        rsv_mask[8]  = 1'b1;
        rsv_mask[40] = 1'b1;
        expect_alloc(8, 96, "R8 reserved groups skipped");
    endtask

    task automatic t_release();
        int ri, re;
        do_req(1'b1, 50, 130, ri, re);
        check(re == 0 && ri == 128, "R9 release of 64-slot group", ri, 128);
        expect_alloc(33, 128, "R9 released group granted again");
        do_req(1'b1, 5, 27, ri, re);
        check(re == 0 && ri == 24, "R9 release of 8-slot group", ri, 24);
        expect_alloc(8, 208, "R5 search continues past hint");
        expect_alloc(8, 216, "R5 next group");
        expect_alloc(8, 24, "R9 freed 8-slot group reused after wrap");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_small_groups();
        t_larger_classes();
        t_too_big();
        t_serialize_noroom();
        t_wrap();
        t_reserve();
        t_release();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule